// File: doc/BRIEF.md
# Maskable Interrupt Register Set for a Serial Peripheral Controller

This block collects interrupt sources from a serial peripheral controller and presents them to software as three registers on a 32-bit word bus: a status register, an enable register and a global enable register. It drives one level interrupt line towards the system.

The controller reports two kinds of source:

- **Single-cycle event pulses:** byte transfer done, transmit underrun, transmit half-empty and receive overrun.
- **Receive levels:** not-empty and full.

Pulses latch sticky status bits. Levels re-assert their bits on every clock for as long as they hold.

Software changes status bits by writing a mask. Every 1 in the mask flips the matching bit, so a single write can clear some bits and set others. When a source and a software write hit the same bit in the same cycle, the source wins.

The interrupt output is a flop fed from the registered state. It therefore reacts one cycle after the registers change and only moves when the masked result changes.

Top module: `spi_irq_regs`

## Requirements
- R1: After reset the global enable, status and enable registers read 0 and `irq_o` is low.
- R2: Register decode on byte addresses:
  - A write to 0x28 loads the enable register with all 32 data bits.
  - Reads of 0x1C, 0x20 and 0x28 return their registers.
  - Any other address, misaligned ones included, reads 0 and a write to it changes no register.
- R3: A write to 0x20 inverts each status bit whose data bit is 1. With no write and no active source, the status register holds its value.
- R4: A transfer-done pulse sets status bit 2 (transmit empty) and bit 8 (receive not-empty) on the next clock edge.
- R5: An overrun pulse sets bit 5, an underrun pulse sets bit 3 and a half-empty pulse sets bit 6. The other bits are left unchanged.
- R6: While the receive not-empty level is high, bit 8 is set on every edge. While the receive full level is high, bit 4 is set on every edge. A software toggle in the same or an earlier cycle does not keep either bit cleared.
- R7: A source that sets a bit wins over a toggle write to the same bit in the same cycle. The bit ends up 1.
- R8: `irq_o` equals, one cycle late, the value of (global enable) AND (at least one bit of status AND enable is 1).
- R9: The global enable register stores only data bit 31. Reads of 0x1C return that bit in position 31 and zeros in every other position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Write strobe for one cycle |
| bus_addr_i | input | AW (8) | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| xfer_done_i | input | 1 | Pulse: one byte transfer completed |
| tx_underrun_i | input | 1 | Pulse: transmit underrun |
| tx_half_empty_i | input | 1 | Pulse: transmit queue half empty |
| rx_overrun_i | input | 1 | Pulse: receive overrun |
| rx_not_empty_i | input | 1 | Level: receive queue holds data |
| rx_full_i | input | 1 | Level: receive queue full |
| irq_o | output | 1 | Registered interrupt request, active high |

## Verification
The following are checked by assertions on every cycle:

- Each source sets its status bit on the following edge.
- The receive levels keep re-asserting their bits.
- The status register holds when there is neither a write nor a source.
- Enable writes load the full word.
- `irq_o` tracks the masked result with exactly one cycle of delay.

The following only the bench scenarios can show:

- The read data of each offset, and that unmapped or misaligned addresses stay inert.
- The exact XOR result of status writes on chosen patterns.
- The masking effect of the enable register and of the global enable bit.
- That a level still wins over a toggle after software tries to clear it.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
  localparam int unsigned DW = 32;

  // byte offsets on the word bus
  localparam logic [7:0] OFS_GEN = 8'h1C;
  localparam logic [7:0] OFS_STS = 8'h20;
  localparam logic [7:0] OFS_ENA = 8'h28;

  // status bit positions
  localparam int unsigned B_TX_EMPTY  = 2;
  localparam int unsigned B_TX_UNDER  = 3;
  localparam int unsigned B_RX_FULL   = 4;
  localparam int unsigned B_RX_OVR    = 5;
  localparam int unsigned B_TX_HALF   = 6;
  localparam int unsigned B_RX_NEMPTY = 8;
  localparam int unsigned B_GEN       = DW - 1;

  typedef struct packed {
    logic xfer_done;
    logic tx_under;
    logic tx_half;
    logic rx_ovr;
    logic rx_nempty;
    logic rx_full;
  } irq_src_t;
endpackage

// File: rtl/spi_irq_decode.sv
module spi_irq_decode
  import spi_irq_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] sts_i,
  input  logic [DW-1:0] en_i,
  input  logic          ge_i,
  output logic          wr_ge_o,
  output logic          wr_sts_o,
  output logic          wr_en_o,
  output logic [DW-1:0] rdata_o
);
  localparam logic [AW-1:0] A_GEN = AW'(OFS_GEN);
  localparam logic [AW-1:0] A_STS = AW'(OFS_STS);
  localparam logic [AW-1:0] A_ENA = AW'(OFS_ENA);

  logic hit_ge, hit_sts, hit_en;

  assign hit_ge  = (addr_i == A_GEN);
  assign hit_sts = (addr_i == A_STS);
  assign hit_en  = (addr_i == A_ENA);

  assign wr_ge_o  = we_i & hit_ge;
  assign wr_sts_o = we_i & hit_sts;
  assign wr_en_o  = we_i & hit_en;

  always_comb begin
    rdata_o = '0;
    if (hit_ge)       rdata_o[B_GEN] = ge_i;
    else if (hit_sts) rdata_o = sts_i;
    else if (hit_en)  rdata_o = en_i;
  end
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
  import spi_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tgl_en_i,
  input  logic [DW-1:0] tgl_i,
  input  irq_src_t      src_i,
  output logic [DW-1:0] sts_o
);
  logic [DW-1:0] set_w;
  logic [DW-1:0] sts_q;

  always_comb begin
    set_w              = '0;
    set_w[B_TX_EMPTY]  = src_i.xfer_done;
    set_w[B_RX_NEMPTY] = src_i.xfer_done | src_i.rx_nempty;
    set_w[B_TX_UNDER]  = src_i.tx_under;
    set_w[B_TX_HALF]   = src_i.tx_half;
    set_w[B_RX_OVR]    = src_i.rx_ovr;
    set_w[B_RX_FULL]   = src_i.rx_full;
  end

  // per-bit: toggle first, set sources override
  for (genvar i = 0; i < DW; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sts_q[i] <= 1'b0;
      else         sts_q[i] <= (sts_q[i] ^ (tgl_en_i & tgl_i[i])) | set_w[i];
    end
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/spi_irq_out.sv
module spi_irq_out
  import spi_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ge_i,
  input  logic [DW-1:0] sts_i,
  input  logic [DW-1:0] en_i,
  output logic          irq_o
);
  logic pend_w, irq_q;

  assign pend_w = ge_i & (|(sts_i & en_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= pend_w;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
  import spi_irq_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [31:0]   bus_wdata_i,
  output logic [31:0]   bus_rdata_o,
  input  logic          xfer_done_i,
  input  logic          tx_underrun_i,
  input  logic          tx_half_empty_i,
  input  logic          rx_overrun_i,
  input  logic          rx_not_empty_i,
  input  logic          rx_full_i,
  output logic          irq_o
);
  logic          wr_ge, wr_sts, wr_en;
  logic          ge_q;
  logic [DW-1:0] en_q;
  logic [DW-1:0] sts_q;
  irq_src_t      src;

  assign src.xfer_done = xfer_done_i;
  assign src.tx_under  = tx_underrun_i;
  assign src.tx_half   = tx_half_empty_i;
  assign src.rx_ovr    = rx_overrun_i;
  assign src.rx_nempty = rx_not_empty_i;
  assign src.rx_full   = rx_full_i;

  spi_irq_decode #(.AW(AW)) u_dec (
    .we_i     (bus_we_i),
    .addr_i   (bus_addr_i),
    .sts_i    (sts_q),
    .en_i     (en_q),
    .ge_i     (ge_q),
    .wr_ge_o  (wr_ge),
    .wr_sts_o (wr_sts),
    .wr_en_o  (wr_en),
    .rdata_o  (bus_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ge_q <= 1'b0;
      en_q <= '0;
    end else begin
      if (wr_ge) ge_q <= bus_wdata_i[B_GEN];
      if (wr_en) en_q <= bus_wdata_i;
    end
  end

  spi_irq_status u_sts (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tgl_en_i (wr_sts),
    .tgl_i    (bus_wdata_i),
    .src_i    (src),
    .sts_o    (sts_q)
  );

  spi_irq_out u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ge_i   (ge_q),
    .sts_i  (sts_q),
    .en_i   (en_q),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/spi_irq_regs_chk.sv
module spi_irq_regs_chk #(
  parameter int unsigned AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_we_i,
  input logic [AW-1:0] bus_addr_i,
  input logic [31:0]   bus_wdata_i,
  input logic          xfer_done_i,
  input logic          tx_underrun_i,
  input logic          tx_half_empty_i,
  input logic          rx_overrun_i,
  input logic          rx_not_empty_i,
  input logic          rx_full_i,
  input logic          ge_q,
  input logic [31:0]   en_q,
  input logic [31:0]   sts_q,
  input logic          irq_o
);
  logic sts_wr, en_wr, any_src;

  assign sts_wr  = bus_we_i && (bus_addr_i == AW'(8'h20));
  assign en_wr   = bus_we_i && (bus_addr_i == AW'(8'h28));
  assign any_src = xfer_done_i | tx_underrun_i | tx_half_empty_i |
                   rx_overrun_i | rx_not_empty_i | rx_full_i;

  // R2
  en_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_wr |=> en_q == $past(bus_wdata_i));

  // R3
  sts_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sts_wr && !any_src) |=> $stable(sts_q));

  // R4
  xfer_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_i |=> (sts_q[2] && sts_q[8]));

  // R5
  overrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_overrun_i |=> sts_q[5]);

  // R5
  underrun_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_underrun_i |=> sts_q[3]);

  // R6
  rx_full_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full_i |=> sts_q[4]);

  // R6
  rx_nempty_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_not_empty_i |=> sts_q[8]);

  // R7
  event_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr && bus_wdata_i[5] && rx_overrun_i) |=> sts_q[5]);

  // R8
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(ge_q && (|(sts_q & en_q))));
endmodule

bind spi_irq_regs spi_irq_regs_chk #(.AW(AW)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .bus_we_i        (bus_we_i),
  .bus_addr_i      (bus_addr_i),
  .bus_wdata_i     (bus_wdata_i),
  .xfer_done_i     (xfer_done_i),
  .tx_underrun_i   (tx_underrun_i),
  .tx_half_empty_i (tx_half_empty_i),
  .rx_overrun_i    (rx_overrun_i),
  .rx_not_empty_i  (rx_not_empty_i),
  .rx_full_i       (rx_full_i),
  .ge_q            (ge_q),
  .en_q            (en_q),
  .sts_q           (sts_q),
  .irq_o           (irq_o)
);

// File: tb/sim_spi_irq_regs.sv
`timescale 1ns/1ps
module sim_spi_irq_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ev_done = 0, ev_under = 0, ev_half = 0, ev_ovr = 0;
  logic        lv_ne = 0, lv_full = 0;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_irq_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .xfer_done_i(ev_done),
    .tx_underrun_i(ev_under), .tx_half_empty_i(ev_half),
    .rx_overrun_i(ev_ovr), .rx_not_empty_i(lv_ne), .rx_full_i(lv_full),
    .irq_o(irq)
  );

  // behavioural reference
  logic [31:0] m_sts, m_en;
  logic        m_ge, m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sts = 0; m_en = 0; m_ge = 0; m_irq = 0;
    end else begin
      m_irq = m_ge && ((m_sts & m_en) != 0);
      if (we && addr == 8'h20) m_sts = m_sts ^ wdata;
      if (we && addr == 8'h28) m_en = wdata;
      if (we && addr == 8'h1C) m_ge = wdata[31];
      if (ev_done)  m_sts = m_sts | 32'h104;
      if (ev_under) m_sts = m_sts | 32'h008;
      if (ev_half)  m_sts = m_sts | 32'h040;
      if (ev_ovr)   m_sts = m_sts | 32'h020;
      if (lv_ne)    m_sts = m_sts | 32'h100;
      if (lv_full)  m_sts = m_sts | 32'h010;
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    case (a)
      8'h1C:   return {m_ge, 31'b0};
      8'h20:   return m_sts;
      8'h28:   return m_en;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({31'b0, irq}, {31'b0, m_irq}, "R8 model irq");
      chk(rdata, m_read(addr), "R2 model rdata");
    end
  end

  task automatic idle();
    @(negedge clk); #1;
    we = 0; ev_done = 0; ev_under = 0; ev_half = 0; ev_ovr = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1; we = 1; addr = a; wdata = d;
    @(negedge clk); #1; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string req);
    addr = a; #1; chk(rdata, e, req);
  endtask

  task automatic pulse(input bit d, input bit u, input bit h, input bit o);
    @(negedge clk); #1; ev_done = d; ev_under = u; ev_half = h; ev_ovr = o;
    @(negedge clk); #1; ev_done = 0; ev_under = 0; ev_half = 0; ev_ovr = 0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #35 rst_n = 1;
    @(negedge clk); #1;
    // R1 reset state
    rd(8'h1C, 0, "R1 ge"); rd(8'h20, 0, "R1 sts"); rd(8'h28, 0, "R1 en");
    chk({31'b0, irq}, 0, "R1 irq");

    wr(8'h28, 32'hFFFF_FFFF); rd(8'h28, 32'hFFFF_FFFF, "R2 en readback");
    wr(8'h1C, 32'hFFFF_FFFF); rd(8'h1C, 32'h8000_0000, "R9 ge bit31 only");
    wr(8'h24, 32'h1234_5678); rd(8'h24, 0, "R2 unmapped");
    rd(8'h28, 32'hFFFF_FFFF, "R2 unmapped no effect");
    wr(8'h21, 32'h0000_00FF); rd(8'h20, 0, "R2 misaligned ignored");
    chk({31'b0, irq}, 0, "R8 idle irq");

    pulse(1, 0, 0, 0); rd(8'h20, 32'h104, "R4 done sets 2 and 8");
    chk({31'b0, irq}, 0, "R8 lag");
    idle(); chk({31'b0, irq}, 1, "R8 assert");

    wr(8'h20, 32'h104); rd(8'h20, 0, "R3 toggle clear");
    idle(); chk({31'b0, irq}, 0, "R8 deassert");
    wr(8'h20, 32'h3); rd(8'h20, 32'h3, "R3 toggle set");
    wr(8'h20, 32'h1); rd(8'h20, 32'h2, "R3 toggle mixed");

    pulse(0, 0, 0, 1); rd(8'h20, 32'h22, "R5 overrun bit5");
    pulse(0, 1, 1, 0); rd(8'h20, 32'h6A, "R5 underrun and half");
    wr(8'h20, 32'h6A); rd(8'h20, 0, "R3 clear all");

    @(negedge clk); #1; lv_ne = 1; lv_full = 1;
    @(negedge clk); #1; rd(8'h20, 32'h110, "R6 levels set");
    wr(8'h20, 32'h110); rd(8'h20, 32'h110, "R6 levels reassert");
    @(negedge clk); #1; lv_ne = 0; lv_full = 0;
    wr(8'h20, 32'h110); rd(8'h20, 0, "R6 released clears");

    pulse(0, 0, 0, 1);
    @(negedge clk); #1; we = 1; addr = 8'h20; wdata = 32'h20; ev_ovr = 1;
    @(negedge clk); #1; we = 0; ev_ovr = 0;
    rd(8'h20, 32'h20, "R7 event wins");

    idle(); chk({31'b0, irq}, 1, "R8 enabled");
    wr(8'h28, 32'hFFFF_FFDF); idle(); chk({31'b0, irq}, 0, "R8 masked");
    wr(8'h28, 32'h20); wr(8'h1C, 0); idle(); chk({31'b0, irq}, 0, "R8 global off");
    wr(8'h1C, 32'h8000_0000); idle(); idle(); chk({31'b0, irq}, 1, "R8 global on");

    idle();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule